// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the array address for every cycle of a four-beat memory burst. A start cycle captures a full external address. Each following continue cycle steps the two least significant address bits to the next beat. The upper bits stay as they were captured. The stepping follows one of two wrap orders, picked by a mode pin that is held steady during operation:

- In the interleaved order, the beat number is XORed into the captured low bits.
- In the linear order, the low bits count upward modulo four.

One control pin serves both purposes: low starts a burst and high advances it. An active-low clock enable can freeze the sequencer on any edge. The address is held from registers and changes only on an enabled rising edge. There is no data path, so the pins are plain control and status signals and no valid/ready handshake is used.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no enabled edge yet, `arr_addr` is zero.
- R2: On an enabled edge with `adv` low, `arr_addr` becomes the value `ext_addr` had at that edge, whatever the previous state.
- R3: On an enabled edge with `adv` high, bits `ADDR_W-1` down to 2 of `arr_addr` keep their value.
- R4: With `interleave` high (the interleaved order), the low two bits for beats 0 to 3 after a start at offset s are s, s^1, s^2 and s^3. Beat 1 inverts bit 0, beat 2 inverts bit 1 and beat 3 inverts both bits.
- R5: With `interleave` low (the linear order), the low two bits for beats 0 to 3 are s, s+1, s+2 and s+3, each taken modulo 4. A start of 2, for example, gives 2, 3, 0, 1.
- R6: Advance cycles after the fourth beat keep wrapping inside the same four-address group. Beat 4 gives the start address again, beat 5 gives the second address, and so on.
- R7: On an edge where `clk_en_n` is high, `arr_addr` keeps its value, even if that edge carries a load request with a new `ext_addr`.
- R8: A load during an unfinished burst abandons that burst. The next advance steps from the newly loaded address, starting again at beat 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_addr | input | ADDR_W | External start address |
| adv | input | 1 | Low: load `ext_addr` and start a burst. High: advance to the next beat |
| interleave | input | 1 | Static order select. 1 selects interleaved, 0 selects linear |
| clk_en_n | input | 1 | Active-low clock enable. When high, the edge is ignored |
| arr_addr | output | ADDR_W | Current array address |

## Verification
The hardest cases to reach from the ports are the wrap behaviour and a stall that arrives mid-burst.

- Wrap: the stimulus runs each start offset, in both orders, for six advances. This carries every burst past its fourth beat and back into the same group.
- Stall mid-burst: held edges are placed in the middle of a burst and carry a load request with a different address. The sequence must then resume from the beat it was frozen on.
- Abandoned burst: a reload in the middle of a burst shows that the old beat count is dropped.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_origin_reg.sv
module burst_origin_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] cap_addr,
  output logic [ADDR_W-1:0] origin
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      origin <= '0;
    else if (cap_en) origin <= cap_addr;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int LOW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [LOW_W-1:0] beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     beat <= '0;
    else if (clr)   beat <= '0;
    else if (step)  beat <= beat + 1'b1;
  end
endmodule

// File: rtl/burst_order_mux.sv
module burst_order_mux
  import burst_pkg::*;
#(
  parameter int LOW_W = 2
) (
  input  burst_order_e     order,
  input  logic [LOW_W-1:0] start_low,
  input  logic [LOW_W-1:0] beat,
  output logic [LOW_W-1:0] cur_low
);
  logic [LOW_W-1:0] xor_low;
  logic [LOW_W-1:0] sum_low;

  for (genvar b = 0; b < LOW_W; b++) begin : g_xor
    assign xor_low[b] = start_low[b] ^ beat[b];
  end

  assign sum_low = start_low + beat;

  always_comb begin
    if (order == ORD_INTERLEAVE) cur_low = xor_low;
    else                         cur_low = sum_low;
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              adv,
  input  logic              interleave,
  input  logic              clk_en_n,
  output logic [ADDR_W-1:0] arr_addr
);
  localparam int LOW_W = $clog2(BURST_LEN);

  logic              edge_live;
  logic              do_load;
  logic              do_step;
  logic [ADDR_W-1:0] origin;
  logic [LOW_W-1:0]  beat;
  logic [LOW_W-1:0]  cur_low;
  burst_order_e      order;

  assign edge_live = !clk_en_n;
  assign do_load   = edge_live && !adv;
  assign do_step   = edge_live && adv;
  assign order     = interleave ? ORD_INTERLEAVE : ORD_LINEAR;

  burst_origin_reg #(.ADDR_W(ADDR_W)) u_origin (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (do_load),
    .cap_addr (ext_addr),
    .origin   (origin)
  );

  burst_beat_ctr #(.LOW_W(LOW_W)) u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (do_load),
    .step  (do_step),
    .beat  (beat)
  );

  burst_order_mux #(.LOW_W(LOW_W)) u_order (
    .order     (order),
    .start_low (origin[LOW_W-1:0]),
    .beat      (beat),
    .cur_low   (cur_low)
  );

  assign arr_addr = {origin[ADDR_W-1:LOW_W], cur_low};
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              adv,
  input logic              interleave,
  input logic              clk_en_n,
  input logic [ADDR_W-1:0] arr_addr
);
  AST_LOAD_TAKES_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv) |=> arr_addr == $past(ext_addr)); // R2

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv) |=> arr_addr[ADDR_W-1:2] == $past(arr_addr[ADDR_W-1:2])); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv && !interleave) |=>
      (interleave || arr_addr[1:0] == $past(arr_addr[1:0]) + 2'd1)); // R5

  AST_INTERLEAVE_ONE_FLIP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv && interleave) |=>
      (!interleave || arr_addr[1:0] != $past(arr_addr[1:0]))); // R4

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && $stable(interleave)) |=> (!$stable(interleave) || $stable(arr_addr))); // R7

  always_comb begin
    if (!rst_n) begin
      AST_RESET_ZERO: assert (arr_addr == '0); // R1
    end
  end
endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W)) u_burst_seq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ext_addr   (ext_addr),
  .adv        (adv),
  .interleave (interleave),
  .clk_en_n   (clk_en_n),
  .arr_addr   (arr_addr)
);

// File: tb/test_burst_seq.sv
module test_burst_seq;
  localparam int AW = 20;

  typedef struct {
    logic [AW-1:0] exp;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          adv = 1'b1;
  logic          interleave = 1'b1;
  logic          clk_en_n = 1'b1;
  logic [AW-1:0] arr_addr;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;
  item_t sb[$];

  logic [AW-1:0] m_base;
  int            m_beat;

  always #5 clk = ~clk;

  burst_seq #(.ADDR_W(AW), .BURST_LEN(4)) i_burst_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_addr   (ext_addr),
    .adv        (adv),
    .interleave (interleave),
    .clk_en_n   (clk_en_n),
    .arr_addr   (arr_addr)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] s;
    logic [1:0] k;
    logic [1:0] low;
    s = m_base[1:0];
    k = 2'(m_beat % 4);
    if (interleave) low = s ^ k;          // R4
    else            low = 2'((s + k) % 4); // R5
    return {m_base[AW-1:2], low};
  endfunction

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic ce_n, input logic [AW-1:0] addr, input string tag);
    item_t it;
    @(negedge clk);
    adv = a; clk_en_n = ce_n; ext_addr = addr;
    @(posedge clk);
    if (!ce_n) begin
      if (!a) begin m_base = addr; m_beat = 0; end
      else    m_beat++;
    end
    it.exp = model_addr();
    it.tag = tag;
    #1 sb.push_back(it);
  endtask

  task automatic do_load(input logic [AW-1:0] addr, input string tag);
    drive(1'b0, 1'b0, addr, tag);
  endtask

  task automatic do_adv(input string tag);
    drive(1'b1, 1'b0, $urandom(), tag);
  endtask

  task automatic do_stall(input logic [AW-1:0] addr);
    drive(1'b0, 1'b1, addr, "R7 stall hold");
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(arr_addr, it.exp, it.tag);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    m_base = '0;
    m_beat = 0;
    repeat (3) @(negedge clk);
    check(arr_addr, '0, "R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check(arr_addr, '0, "R1 after release");

    for (int mode = 1; mode >= 0; mode--) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a;
        a = {AW'($urandom()) >> 2, 2'(s)} ;
        a = {a[AW-1:2], 2'(s)};
        @(negedge clk);
        interleave = mode[0];
        do_load(a, "R2 load start");
        for (int b = 1; b <= 6; b++) begin
          if (b >= 4)    do_adv("R6 wrap in group");
          else if (mode) do_adv("R4 interleaved beat / R3 upper");
          else           do_adv("R5 linear beat / R3 upper");
        end
      end
    end

    // stall in the middle of a burst, both orders
    for (int mode = 0; mode < 2; mode++) begin
      @(negedge clk);
      interleave = mode[0];
      do_load(20'hABCD2, "R2 load before stall");
      do_adv("R4 R5 beat before stall");
      do_stall(20'h12341);
      do_stall(20'h55550);
      do_adv("R7 resume after stall");
      do_adv("R7 resume second beat");
    end

    // reload in the middle of a burst
    interleave = 1'b0;
    do_load(20'h0F0F1, "R2 first burst");
    do_adv("R5 first beat");
    do_adv("R5 second beat");
    do_load(20'h3C3C3, "R8 reload mid burst");
    do_adv("R8 step from new start");
    do_adv("R8 second step from new start");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule